// File: doc/BRIEF.md
# Two-Word Opcode Decoder

This block sits in the fetch path of a small 4-bit-nibble processor. Each accepted opcode byte is classified into an instruction class. The block also extracts its register, register-pair, immediate or condition operand, and reports two more facts: whether the instruction occupies one or two program words, and whether it needs one or two machine cycles. Word length and cycle count are reported separately, because one single-word class (fetch-indirect) still needs two cycles.

When an opcode needs a second word, the decoder holds a pending flag. It accepts the next valid byte as the operand word and only then signals completion. For the jump and call classes, that byte is joined with the opcode's low nibble to form a 12-bit target. Instruction execution happens elsewhere.

Top module: `nibble_op_decoder`

## Requirements
- R1: After reset: `pend_o`=0, `done_o`=0, `cls_o`=0, `opnd_o`=0, `two_word_o`=0, `cycles_o`=0, `word2_o`=0.
- R2: Byte 1011_rrrr decodes to class 7 (exchange), operand rrrr, one word, one cycle.
- R3: Byte 0011_ppp1 decodes to class 3 (indirect jump), one cycle. Byte 0011_ppp0 decodes to class 2 (fetch-indirect), two cycles. Both are one word, and the operand is the pair index ppp (bits 3:1).
- R4: Byte 1100_dddd decodes to class 8 (return with immediate), operand dddd, one word, one cycle.
- R5: Byte 0100_hhhh decodes to class 4 (jump) and byte 0101_hhhh to class 5 (call). Both are two words and two cycles, and `addr_o` = {hhhh, second byte}.
- R6: Byte 0111_rrrr decodes to class 6 (increment-skip) and byte 0001_cccc to class 1 (conditional jump). Both are two words and two cycles, the operand is the low nibble, and `addr_o` = {0000, second byte}.
- R7: After a two-word opcode is accepted, `pend_o`=1 and `done_o`=0 until the next valid byte. Cycles without valid leave both unchanged. That byte is latched into `word2_o`, `pend_o` clears and `done_o` is high for one cycle.
- R8: A single-word opcode raises `done_o` in the following cycle with `pend_o` staying 0. It leaves `word2_o` unchanged.
- R9: Any other byte decodes to class 0 (other), operand = low nibble, one word, one cycle.
- R10: `done_o` is low in the cycle following any clock edge at which `byte_valid_i` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_i | input | 8 | Fetched program byte |
| byte_valid_i | input | 1 | `byte_i` is valid this cycle |
| cls_o | output | 4 | Instruction class code |
| opnd_o | output | 4 | Operand field |
| two_word_o | output | 1 | Instruction is two words long |
| cycles_o | output | 2 | Machine cycles needed (1 or 2) |
| pend_o | output | 1 | Waiting for the second word |
| done_o | output | 1 | Decode complete pulse |
| word2_o | output | 8 | Latched second word |
| addr_o | output | 12 | Target address for two-word classes |

## Verification
Every decode result is registered once. Class, operand, length and cycle count appear one clock after the opcode byte is accepted. For two-word opcodes, `word2_o`, `addr_o` and `done_o` appear one clock after the second byte. A driver task pushes the expected result into a queue when it presents the byte that completes an instruction. A monitor samples just after each falling edge and pops an item whenever `done_o` is high, so each comparison lands exactly in the cycle the result is due. During idle gaps between the two words, the driver also checks directly that the pending flag holds and that completion stays low.

// File: rtl/nibble_op_decoder.sv
module nibble_op_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  byte_i,
  input  logic        byte_valid_i,
  output logic [3:0]  cls_o,
  output logic [3:0]  opnd_o,
  output logic        two_word_o,
  output logic [1:0]  cycles_o,
  output logic        pend_o,
  output logic        done_o,
  output logic [7:0]  word2_o,
  output logic [11:0] addr_o
);

  localparam logic [3:0] C_OTHER = 4'd0;
  localparam logic [3:0] C_JCOND = 4'd1;
  localparam logic [3:0] C_FIND  = 4'd2;
  localparam logic [3:0] C_JIND  = 4'd3;
  localparam logic [3:0] C_JUMP  = 4'd4;
  localparam logic [3:0] C_CALL  = 4'd5;
  localparam logic [3:0] C_ISZ   = 4'd6;
  localparam logic [3:0] C_XCH   = 4'd7;
  localparam logic [3:0] C_RETLD = 4'd8;

  logic [3:0] hi, lo;
  logic [3:0] d_cls, d_opnd;
  logic       d_two;
  logic [1:0] d_cyc;

  assign hi = byte_i[7:4];
  assign lo = byte_i[3:0];

  always_comb begin
    d_opnd = lo;
    d_two  = 1'b0;
    d_cyc  = 2'd1;
    unique case (hi)
      4'h1: begin d_cls = C_JCOND; d_two = 1'b1; d_cyc = 2'd2; end
      4'h3: begin
        d_opnd = {1'b0, lo[3:1]};
        if (lo[0]) d_cls = C_JIND;
        else begin d_cls = C_FIND; d_cyc = 2'd2; end
      end
      4'h4: begin d_cls = C_JUMP; d_two = 1'b1; d_cyc = 2'd2; end
      4'h5: begin d_cls = C_CALL; d_two = 1'b1; d_cyc = 2'd2; end
      4'h7: begin d_cls = C_ISZ;  d_two = 1'b1; d_cyc = 2'd2; end
      4'hB: d_cls = C_XCH;
      4'hC: d_cls = C_RETLD;
      default: d_cls = C_OTHER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cls_o      <= C_OTHER;
      opnd_o     <= 4'h0;
      two_word_o <= 1'b0;
      cycles_o   <= 2'd0;
      pend_o     <= 1'b0;
      done_o     <= 1'b0;
      word2_o    <= 8'h00;
    end else begin
      done_o <= 1'b0;
      if (byte_valid_i) begin
        if (pend_o) begin
          word2_o <= byte_i;
          pend_o  <= 1'b0;
          done_o  <= 1'b1;
        end else begin
          cls_o      <= d_cls;
          opnd_o     <= d_opnd;
          two_word_o <= d_two;
          cycles_o   <= d_cyc;
          pend_o     <= d_two;
          done_o     <= !d_two;
        end
      end
    end
  end

  assign addr_o = {((cls_o == C_JUMP) || (cls_o == C_CALL)) ? opnd_o : 4'h0, word2_o};

endmodule

// File: rtl/nibble_op_decoder_chk.sv
module nibble_op_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  byte_i,
  input logic        byte_valid_i,
  input logic [3:0]  cls_o,
  input logic        two_word_o,
  input logic [1:0]  cycles_o,
  input logic        pend_o,
  input logic        done_o
);

  AST_NO_DONE_WHILE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && pend_o)); // R7

  AST_PEND_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o && byte_valid_i |=> !pend_o && done_o); // R7

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o && !byte_valid_i |=> pend_o && $stable(cls_o)); // R7

  AST_JUMP_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_o && byte_valid_i && (byte_i[7:4] == 4'h4) |=> pend_o && cls_o == 4'd4); // R5

  AST_XCH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_o && byte_valid_i && (byte_i[7:4] == 4'hB) |=> done_o && !pend_o); // R2

  AST_TWO_WORD_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && two_word_o |-> cycles_o == 2'd2); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid_i |=> !done_o); // R10

endmodule

bind nibble_op_decoder nibble_op_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_i(byte_i), .byte_valid_i(byte_valid_i),
  .cls_o(cls_o), .two_word_o(two_word_o), .cycles_o(cycles_o),
  .pend_o(pend_o), .done_o(done_o)
);

// File: tb/sim_nibble_op_decoder.sv
module sim_nibble_op_decoder;
  logic clk = 1'b0, rst_n = 1'b0, byte_valid_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic [3:0] cls_o, opnd_o;
  logic two_word_o, pend_o, done_o;
  logic [1:0] cycles_o;
  logic [7:0] word2_o;
  logic [11:0] addr_o;

  always #5 clk = ~clk;

  nibble_op_decoder u0 (.*);

  typedef struct packed {
    logic [3:0] c; logic [3:0] o; logic t; logic [1:0] y; logic [11:0] a; logic [7:0] tag;
  } exp_t;

  exp_t q[$];
  int compared = 0, mismatched = 0;
  logic [7:0] last_w2 = 8'h00;

  task automatic chk(input bit ok, input string req, input string msg);
    compared++;
    if (!ok) begin mismatched++; $display("FAIL %s: %s", req, msg); end
  endtask

  function automatic exp_t model(input logic [7:0] b, input logic [7:0] w);
    exp_t e;
    e = '0; e.o = b[3:0]; e.y = 2'd1; e.tag = b;
    case (b[7:4])
      4'h1: begin e.c = 4'd1; e.t = 1; e.y = 2; e.a = {4'h0, w}; end
      4'h3: begin e.o = {1'b0, b[3:1]}; e.c = b[0] ? 4'd3 : 4'd2; e.y = b[0] ? 2'd1 : 2'd2; end
      4'h4: begin e.c = 4'd4; e.t = 1; e.y = 2; e.a = {b[3:0], w}; end
      4'h5: begin e.c = 4'd5; e.t = 1; e.y = 2; e.a = {b[3:0], w}; end
      4'h7: begin e.c = 4'd6; e.t = 1; e.y = 2; e.a = {4'h0, w}; end
      4'hB: e.c = 4'd7;
      4'hC: e.c = 4'd8;
      default: e.c = 4'd0;
    endcase
    return e;
  endfunction

  task automatic put(input logic [7:0] b);
    @(negedge clk); byte_i = b; byte_valid_i = 1'b1;
    @(negedge clk); byte_valid_i = 1'b0;
  endtask

  // R8: single-word op, word2_o must keep its last value
  task automatic op1(input logic [7:0] b);
    q.push_back(model(b, 8'h00));
    put(b);
    #1 chk(!pend_o && word2_o == last_w2, "R8",
           $sformatf("pend=%0b word2=%h exp pend=0 word2=%h", pend_o, word2_o, last_w2));
  endtask

  // R7: two-word op with idle gap
  task automatic op2(input logic [7:0] b, input logic [7:0] w, input int gap);
    put(b);
    #1 chk(pend_o && !done_o, "R7", $sformatf("pend=%0b done=%0b exp 1/0", pend_o, done_o));
    for (int i = 0; i < gap; i++) begin
      @(negedge clk); #1
      chk(pend_o && !done_o, "R7", $sformatf("gap pend=%0b done=%0b exp 1/0", pend_o, done_o));
    end
    q.push_back(model(b, w));
    put(w);
    last_w2 = w;
    #1 chk(word2_o == w && !pend_o, "R7",
           $sformatf("word2=%h pend=%0b exp %h/0", word2_o, pend_o, w));
  endtask

  // monitor
  initial forever begin
    @(negedge clk); #1;
    if (rst_n && done_o) begin
      if (q.size() == 0) chk(0, "R10", "done_o with no expected item");
      else begin
        exp_t e;
        e = q.pop_front();
        chk(cls_o == e.c && opnd_o == e.o && two_word_o == e.t && cycles_o == e.y &&
            (!e.t || addr_o == e.a), (e.tag[7:4]==4'hB) ? "R2" : (e.tag[7:4]==4'h3) ? "R3" :
            (e.tag[7:4]==4'hC) ? "R4" : (e.tag[7:4]==4'h4 || e.tag[7:4]==4'h5) ? "R5" :
            (e.t) ? "R6" : "R9",
            $sformatf("op %h: cls=%0d opnd=%h two=%0b cyc=%0d addr=%h exp cls=%0d opnd=%h two=%0b cyc=%0d addr=%h",
                      e.tag, cls_o, opnd_o, two_word_o, cycles_o, addr_o, e.c, e.o, e.t, e.y, e.a));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk(!pend_o && !done_o && cls_o == 0 && opnd_o == 0 && !two_word_o && cycles_o == 0 && word2_o == 0,
           "R1", $sformatf("pend=%0b done=%0b cls=%0d opnd=%h cyc=%0d w2=%h exp all zero",
                           pend_o, done_o, cls_o, opnd_o, cycles_o, word2_o));
    @(negedge clk); rst_n = 1'b1;
    op1(8'hB5); op1(8'hBF);
    op1(8'h37); op1(8'h3C); op1(8'h31);
    op1(8'hC9);
    op2(8'h4A, 8'h3E, 0);
    op2(8'h5F, 8'hFF, 3);
    op1(8'h30);
    op2(8'h72, 8'h81, 1);
    op2(8'h16, 8'h40, 2);
    op1(8'h00); op1(8'hE3); op1(8'h2A);
    // back-to-back single-word ops
    q.push_back(model(8'hB1, 0)); q.push_back(model(8'hC2, 0));
    @(negedge clk); byte_i = 8'hB1; byte_valid_i = 1;
    @(negedge clk); byte_i = 8'hC2;
    @(negedge clk); byte_valid_i = 0;
    #1 chk(done_o, "R8", $sformatf("done=%0b exp 1", done_o));
    @(negedge clk); #1 chk(!done_o, "R10", $sformatf("done=%0b exp 0", done_o));
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R7", $sformatf("queue left %0d exp 0", q.size()));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule